// File: doc/BRIEF.md
# External Bus Chip-Select Controller

This block sits between a processor's data port and an external 16-bit asynchronous memory bus. Every access the processor starts is checked against an address window and a set of per-bank base, size and enable settings. A matching access is given to one of up to eight chip selects. A non-matching or misaligned access is returned at once with an error flag and never touches the bus.

Each bank carries its own timing and width settings: a wait-state count that stretches every strobe, a data-float count that keeps the bus quiet after the bank releases it, and a flag that selects a 16-bit or 8-bit device. Processor accesses wider than the device are split into sequential narrower cycles. On reads, the returned bytes are reassembled into their natural 32-bit lanes. The processor side uses a simple ready/request/done handshake.

Top module: `ebi_cs_ctrl`

## Requirements
- R1: An address below 0x0040_0000, or at or above 0xFFC0_0000, is undefined. It ends with `done` and `err` both high in the cycle after the request, and no chip select or strobe is driven.
- R2: A bank matches when it is enabled and address bits [31:20] equal its 12-bit base, ignoring the low `c` bits, where the span is 1 MB << `c` (size code `c`, with codes above 4 taken as 4, giving 16 MB). When several banks match, the lowest index wins. When none matches, the access ends as in R1.
- R3: At most one active-low chip select is low at any time. It is the selected bank's select, and it is low exactly while `rd_n` (read) or `wr_n` (write) is low. The two strobes are never low together.
- R4: Each bus cycle holds its strobe low for wait-state count + 1 clock cycles.
- R5: A 16-bit bank runs a word access as two half-word cycles and any other access as one cycle. An 8-bit bank runs byte, half-word and word accesses as 1, 2 and 4 byte cycles. Cycles go in ascending address order. Size encoding: 0 byte, 1 half-word, 2 (or 3) word.
- R6: On a 16-bit bank, `be_n[0]` enables the even byte on `ext_wdata[7:0]` and `be_n[1]` enables the odd byte on `ext_wdata[15:8]`, both active low. A byte access enables only its own lane. On an 8-bit bank, `be_n` is 2'b10 and the byte is on `ext_wdata[7:0]`.
- R7: For a read, `rdata` places each byte read from address x in lane x[1:0] (bits 8*x[1:0]+7 down to 8*x[1:0]). Lanes that were not accessed read as zero.
- R8: After an access to a bank with float count F, a following access to a different bank, or in the opposite direction, waits before its first strobe. The wait is F minus the number of idle cycles that passed after the `done` cycle, floored at zero. An access to the same bank in the same direction never waits.
- R9: A half-word at an odd address, or a word whose address bits [1:0] are not zero, ends as in R1.
- R10: `ready` is high whenever the controller is idle, and a request is taken only then. `done` is a one-cycle pulse in the cycle after the last strobe cycle. `err` is high only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, sampled while ready |
| we | input | 1 | 1 write, 0 read |
| addr | input | AW | Byte address |
| size | input | 2 | 0 byte, 1 half-word, 2/3 word |
| wdata | input | 32 | Write data in natural lanes |
| ready | output | 1 | Controller idle |
| done | output | 1 | Access finished (one cycle) |
| err | output | 1 | Undefined or misaligned access |
| rdata | output | 32 | Read data, valid with done |
| cfg_en | input | NBANK | Per-bank enable |
| cfg_base | input | NBANK*12 | Per-bank base, address bits [31:20] |
| cfg_szc | input | NBANK*SZC_W | Per-bank size code |
| cfg_w16 | input | NBANK | 1 for a 16-bit device, 0 for an 8-bit device |
| cfg_ws | input | NBANK*WS_W | Per-bank wait states |
| cfg_flt | input | NBANK*FLT_W | Per-bank data-float cycles |
| cs_n | output | NBANK | Active-low chip selects |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| be_n | output | 2 | Active-low byte enables |
| ext_addr | output | AW | External byte address of the current cycle |
| ext_wdata | output | 16 | External write data |
| ext_rdata | input | 16 | External read data |

## Verification
The checker watches the bus signals on every cycle. It confirms that at most one chip select is low, that a chip select is low only with exactly one strobe, that the select holds steady across a strobe, that the controller is never ready mid-access, and that `err` comes only as a single-cycle `done` with no select driven. Other properties can only be shown by the bench's scenarios: the strobe length per wait state, the splitting of wide accesses into beats, lane steering on writes, reassembly of read data, which bank wins when regions overlap, and the float delay after a change of bank or direction, including its shortening by idle cycles.

// File: rtl/ebi_pkg.sv
package ebi_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FLOAT  = 2'd1,
        ST_STROBE = 2'd2
    } ebi_state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    // number of bus cycles one processor access needs on a device of the given width
    function automatic logic [2:0] beat_count(input logic wide16, input logic [1:0] sz);
        logic [2:0] n;
        if (wide16) begin
            n = (sz == SZ_WORD) ? 3'd2 : 3'd1;
        end else begin
            case (sz)
                SZ_BYTE: n = 3'd1;
                SZ_HALF: n = 3'd2;
                default: n = 3'd4;
            endcase
        end
        return n;
    endfunction

endpackage

// File: rtl/ebi_bank_match.sv
module ebi_bank_match #(
    parameter int PAGE_W = 12,
    parameter int SZC_W  = 3
) (
    input  logic [PAGE_W-1:0] page,
    input  logic [PAGE_W-1:0] base,
    input  logic [SZC_W-1:0]  szc,
    input  logic              en,
    output logic              hit
);
    localparam int MAX_CODE = 4;

    logic [SZC_W-1:0]  lim;
    logic [PAGE_W-1:0] mask;

    always_comb begin
        lim  = (szc > SZC_W'(MAX_CODE)) ? SZC_W'(MAX_CODE) : szc;
        mask = {PAGE_W{1'b1}} << lim;
        hit  = en && (((page ^ base) & mask) == '0);
    end
endmodule

// File: rtl/ebi_prio_pick.sv
module ebi_prio_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  hits,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |hits;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/ebi_lane_steer.sv
module ebi_lane_steer
    import ebi_pkg::*;
(
    input  logic        wide16,
    input  logic [1:0]  sz,
    input  logic [1:0]  ea,
    input  logic [31:0] wdata,
    input  logic [15:0] ext_rdata,
    input  logic [31:0] rdata_in,
    output logic [1:0]  be_n,
    output logic [15:0] ext_wdata,
    output logic [31:0] rdata_out
);
    logic [7:0] wbyte;

    always_comb begin
        wbyte     = wdata[{ea, 3'b000} +: 8];
        rdata_out = rdata_in;
        if (wide16) begin
            if (sz == SZ_BYTE) be_n = ea[0] ? 2'b01 : 2'b10;
            else               be_n = 2'b00;
            ext_wdata = ea[1] ? wdata[31:16] : wdata[15:0];
            if (!be_n[0]) rdata_out[{ea[1], 1'b0, 3'b000} +: 8] = ext_rdata[7:0];
            if (!be_n[1]) rdata_out[{ea[1], 1'b1, 3'b000} +: 8] = ext_rdata[15:8];
        end else begin
            be_n      = 2'b10;
            ext_wdata = {wbyte, wbyte};
            rdata_out[{ea, 3'b000} +: 8] = ext_rdata[7:0];
        end
    end
endmodule

// File: rtl/ebi_cs_ctrl.sv
module ebi_cs_ctrl
    import ebi_pkg::*;
#(
    parameter int NBANK = 8,
    parameter int AW    = 32,
    parameter int WS_W  = 4,
    parameter int FLT_W = 3,
    parameter int SZC_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req,
    input  logic                     we,
    input  logic [AW-1:0]            addr,
    input  logic [1:0]               size,
    input  logic [31:0]              wdata,
    output logic                     ready,
    output logic                     done,
    output logic                     err,
    output logic [31:0]              rdata,
    input  logic [NBANK-1:0]         cfg_en,
    input  logic [NBANK*12-1:0]      cfg_base,
    input  logic [NBANK*SZC_W-1:0]   cfg_szc,
    input  logic [NBANK-1:0]         cfg_w16,
    input  logic [NBANK*WS_W-1:0]    cfg_ws,
    input  logic [NBANK*FLT_W-1:0]   cfg_flt,
    output logic [NBANK-1:0]         cs_n,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic [1:0]               be_n,
    output logic [AW-1:0]            ext_addr,
    output logic [15:0]              ext_wdata,
    input  logic [15:0]              ext_rdata
);
    localparam int PAGE_W = 12;
    localparam int PAGE_LO = AW - PAGE_W;
    localparam int BIDX_W = (NBANK > 1) ? $clog2(NBANK) : 1;
    localparam logic [AW-1:0] WIN_LO = AW'(32'h0040_0000);
    localparam logic [AW-1:0] WIN_HI = AW'(32'hFFC0_0000);

    typedef struct packed {
        ebi_state_e        st;
        logic [BIDX_W-1:0] bank;
        logic              we;
        logic [1:0]        sz;
        logic              w16;
        logic [AW-1:0]     addr;
        logic [31:0]       wdata;
        logic [2:0]        beats;
        logic [WS_W-1:0]   ws;
        logic [WS_W-1:0]   cnt;
        logic [FLT_W-1:0]  fcnt;
        logic [31:0]       rdata;
        logic              done;
        logic              err;
        logic              last_vld;
        logic [BIDX_W-1:0] last_bank;
        logic              last_we;
        logic [FLT_W-1:0]  flt_left;
    } ctrl_t;

    ctrl_t q, d;

    logic [NBANK-1:0]  hit;
    logic              hit_any;
    logic [BIDX_W-1:0] hit_idx;
    logic [1:0]        be_s;
    logic [31:0]       rdata_m;
    logic [1:0]        sz_n;
    logic              in_win, misal, start, conflict, strobe;

    // one address comparator per bank
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        ebi_bank_match #(.PAGE_W(PAGE_W), .SZC_W(SZC_W)) u_match (
            .page (addr[AW-1:PAGE_LO]),
            .base (cfg_base[b*PAGE_W +: PAGE_W]),
            .szc  (cfg_szc[b*SZC_W +: SZC_W]),
            .en   (cfg_en[b]),
            .hit  (hit[b])
        );
    end

    ebi_prio_pick #(.N(NBANK), .IW(BIDX_W)) u_pick (
        .hits (hit),
        .any  (hit_any),
        .idx  (hit_idx)
    );

    ebi_lane_steer u_lane (
        .wide16    (q.w16),
        .sz        (q.sz),
        .ea        (q.addr[1:0]),
        .wdata     (q.wdata),
        .ext_rdata (ext_rdata),
        .rdata_in  (q.rdata),
        .be_n      (be_s),
        .ext_wdata (ext_wdata),
        .rdata_out (rdata_m)
    );

    always_comb begin
        sz_n     = (size == 2'd3) ? SZ_WORD : size;
        in_win   = (addr >= WIN_LO) && (addr < WIN_HI);
        misal    = ((sz_n == SZ_HALF) && addr[0]) || ((sz_n == SZ_WORD) && (addr[1:0] != 2'b00));
        start    = (q.st == ST_IDLE) && req && in_win && hit_any && !misal;
        conflict = q.last_vld && (q.flt_left != '0) &&
                   ((hit_idx != q.last_bank) || (we != q.last_we));

        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;

        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.bank     = hit_idx;
                    d.we       = we;
                    d.sz       = sz_n;
                    d.w16      = cfg_w16[hit_idx];
                    d.addr     = addr;
                    d.wdata    = wdata;
                    d.beats    = beat_count(cfg_w16[hit_idx], sz_n);
                    d.ws       = cfg_ws[hit_idx*WS_W +: WS_W];
                    d.cnt      = cfg_ws[hit_idx*WS_W +: WS_W];
                    d.rdata    = '0;
                    d.flt_left = '0;
                    if (conflict) begin
                        d.st   = ST_FLOAT;
                        d.fcnt = q.flt_left;
                    end else begin
                        d.st   = ST_STROBE;
                    end
                end else begin
                    if (req) begin
                        d.done = 1'b1;
                        d.err  = 1'b1;
                    end
                    if (q.flt_left != '0) d.flt_left = q.flt_left - 1'b1;
                end
            end
            ST_FLOAT: begin
                if (q.fcnt <= FLT_W'(1)) d.st = ST_STROBE;
                else                     d.fcnt = q.fcnt - 1'b1;
            end
            ST_STROBE: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else begin
                    if (!q.we) d.rdata = rdata_m;
                    if (q.beats <= 3'd1) begin
                        d.st        = ST_IDLE;
                        d.done      = 1'b1;
                        d.last_vld  = 1'b1;
                        d.last_bank = q.bank;
                        d.last_we   = q.we;
                        d.flt_left  = cfg_flt[q.bank*FLT_W +: FLT_W];
                    end else begin
                        d.beats = q.beats - 3'd1;
                        d.addr  = q.addr + (q.w16 ? AW'(2) : AW'(1));
                        d.cnt   = q.ws;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        strobe   = (q.st == ST_STROBE);
        ready    = (q.st == ST_IDLE);
        done     = q.done;
        err      = q.err;
        rdata    = q.rdata;
        cs_n     = strobe ? ~(NBANK'(1) << q.bank) : '1;
        rd_n     = !(strobe && !q.we);
        wr_n     = !(strobe && q.we);
        be_n     = strobe ? be_s : 2'b11;
        ext_addr = q.addr;
    end
endmodule

// File: rtl/ebi_cs_ctrl_chk.sv
module ebi_cs_ctrl_chk #(
    parameter int NBANK = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NBANK-1:0] cs_n,
    input logic             rd_n,
    input logic             wr_n,
    input logic             done,
    input logic             err,
    input logic             ready
);
    logic sel;
    assign sel = (cs_n != {NBANK{1'b1}});

    assert_one_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    assert_cs_has_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sel |-> (!rd_n || !wr_n));

    assert_strobe_has_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> sel);

    assert_rw_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    assert_cs_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && $past(sel)) |-> $stable(cs_n));

    assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sel |-> !ready);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_err_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (done && ready));

    assert_err_no_cs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !sel);
endmodule

bind ebi_cs_ctrl ebi_cs_ctrl_chk #(.NBANK(NBANK)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (cs_n),
    .rd_n  (rd_n),
    .wr_n  (wr_n),
    .done  (done),
    .err   (err),
    .ready (ready)
);

// File: tb/sim_ebi_cs_ctrl.sv
module sim_ebi_cs_ctrl;
    localparam int NB = 8;
    localparam logic [7:0] W16 = 8'b0111_0101; // banks 0,2,4,5,6 are 16-bit

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, we = 1'b0;
    logic [31:0] addr = '0, wdata = '0;
    logic [1:0] size = '0;
    logic ready, done, err;
    logic [31:0] rdata;
    logic [NB-1:0] cfg_en, cfg_w16;
    logic [NB*12-1:0] cfg_base;
    logic [NB*3-1:0] cfg_szc, cfg_flt;
    logic [NB*4-1:0] cfg_ws;
    logic [NB-1:0] cs_n;
    logic rd_n, wr_n;
    logic [1:0] be_n;
    logic [31:0] ext_addr;
    logic [15:0] ext_wdata, ext_rdata;

    int nchk = 0, nerr = 0;
    bit summary_done = 0;

    always #10 clk = ~clk;

    ebi_cs_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .size(size),
        .wdata(wdata), .ready(ready), .done(done), .err(err), .rdata(rdata),
        .cfg_en(cfg_en), .cfg_base(cfg_base), .cfg_szc(cfg_szc), .cfg_w16(cfg_w16),
        .cfg_ws(cfg_ws), .cfg_flt(cfg_flt), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .be_n(be_n), .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
    );

    function automatic logic [7:0] fmem(input logic [31:0] x);
        return x[7:0] ^ 8'hA5;
    endfunction

    // external device model: data depends only on address and device width
    always_comb begin
        ext_rdata = '0;
        for (int k = 0; k < NB; k++) begin
            if (!cs_n[k]) begin
                if (W16[k]) ext_rdata = {fmem(ext_addr | 32'd1), fmem(ext_addr & ~32'd1)};
                else        ext_rdata = {8'h00, fmem(ext_addr)};
            end
        end
    end

    function automatic logic [3:0] exp_mask(input logic [31:0] a, input logic [1:0] s);
        logic [3:0] m;
        m = (s == 2'd0) ? 4'b0001 : (s == 2'd1) ? 4'b0011 : 4'b1111;
        return m << a[1:0];
    endfunction

    function automatic logic [31:0] m32(input logic [3:0] m);
        return {{8{m[3]}}, {8{m[2]}}, {8{m[1]}}, {8{m[0]}}};
    endfunction

    function automatic logic [31:0] exp_rd(input logic [31:0] a, input logic [1:0] s);
        logic [31:0] r;
        logic [3:0] m;
        m = exp_mask(a, s);
        r = '0;
        for (int l = 0; l < 4; l++)
            if (m[l]) r[8*l +: 8] = fmem({a[31:2], 2'(l)});
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] expv);
        nchk++;
        if (got !== expv) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, got, expv);
        end
    endtask

    task automatic run_acc(input logic [31:0] a, input logic [1:0] s, input logic w,
                           input logic [31:0] wd, output int lead, output int nstb,
                           output int tot, output int csi, output logic ef,
                           output logic [31:0] rd, output logic [31:0] wimg,
                           output logic [3:0] wm);
        logic seen, fin, rdy_bad;
        int act;
        logic [31:0] ba;
        lead = 0; nstb = 0; tot = -1; csi = -1; ef = 0; rd = '0; wimg = '0; wm = '0;
        seen = 0; fin = 0; rdy_bad = 0;
        addr = a; size = s; we = w; wdata = wd; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        for (int cyc = 0; cyc < 64 && !fin; cyc++) begin
            if (cs_n != '1) begin
                act = -1;
                for (int k = 0; k < NB; k++) if (!cs_n[k]) act = k;
                if (!seen) begin seen = 1; lead = cyc; csi = act; end
                nstb++;
                if (ready) rdy_bad = 1;
                if (!wr_n && act >= 0) begin
                    if (W16[act]) begin
                        for (int j = 0; j < 2; j++) begin
                            if (!be_n[j]) begin
                                ba = (ext_addr & ~32'd1) + 32'(j);
                                wimg[8*ba[1:0] +: 8] = ext_wdata[8*j +: 8];
                                wm[ba[1:0]] = 1'b1;
                            end
                        end
                    end else begin
                        wimg[8*ext_addr[1:0] +: 8] = ext_wdata[7:0];
                        wm[ext_addr[1:0]] = 1'b1;
                    end
                end
            end
            if (done) begin
                fin = 1; tot = cyc; ef = err; rd = rdata;
            end else begin
                @(negedge clk);
            end
        end
        chk("R10 access completes with done", 32'(fin), 32'd1);
        chk("R10 ready low during strobe", 32'(rdy_bad), 32'd0);
    endtask

    typedef struct packed {
        logic [31:0] a;
        logic [1:0]  sz;
        logic        w;
        logic [31:0] wd;
        logic [3:0]  bank;   // 15 = undefined
        logic [3:0]  nstb;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VT [NV] = '{
        '{32'h0040_0010, 2'd2, 1'b1, 32'h1122_3344, 4'd0,  4'd4},
        '{32'h0040_0010, 2'd2, 1'b0, 32'h0,         4'd0,  4'd4},
        '{32'h0040_0013, 2'd0, 1'b1, 32'hAB00_0000, 4'd0,  4'd2},
        '{32'h0040_0012, 2'd1, 1'b0, 32'h0,         4'd0,  4'd2},
        '{32'h0100_0021, 2'd0, 1'b0, 32'h0,         4'd1,  4'd1},
        '{32'h0100_0022, 2'd1, 1'b1, 32'hBEEF_0000, 4'd1,  4'd2},
        '{32'h01F0_0004, 2'd2, 1'b0, 32'h0,         4'd1,  4'd4},
        '{32'h0200_0008, 2'd3, 1'b1, 32'hCAFE_F00D, 4'd2,  4'd6},
        '{32'h0050_0000, 2'd2, 1'b0, 32'h0,         4'd15, 4'd0},
        '{32'h0000_1000, 2'd2, 1'b0, 32'h0,         4'd15, 4'd0},
        '{32'hFFC0_0000, 2'd0, 1'b0, 32'h0,         4'd15, 4'd0},
        '{32'h0300_0000, 2'd0, 1'b1, 32'h0,         4'd15, 4'd0},
        '{32'h0040_0002, 2'd2, 1'b0, 32'h0,         4'd15, 4'd0},
        '{32'h0040_0001, 2'd1, 1'b1, 32'h0,         4'd15, 4'd0}
    };

    task automatic set_bank(input int b, input logic [11:0] base, input logic [2:0] szc,
                            input logic en, input logic [3:0] ws, input logic [2:0] flt);
        cfg_base[b*12 +: 12] = base;
        cfg_szc[b*3 +: 3]    = szc;
        cfg_en[b]            = en;
        cfg_w16[b]           = W16[b];
        cfg_ws[b*4 +: 4]     = ws;
        cfg_flt[b*3 +: 3]    = flt;
    endtask

    initial begin
        int lead, nstb, tot, csi;
        logic ef;
        logic [31:0] rd, wimg;
        logic [3:0] wm, em;

        cfg_en = '0; cfg_w16 = '0; cfg_base = '0; cfg_szc = '0; cfg_ws = '0; cfg_flt = '0;
        set_bank(0, 12'h004, 3'd0, 1'b1, 4'd1, 3'd2);
        set_bank(1, 12'h010, 3'd4, 1'b1, 4'd0, 3'd3);
        set_bank(2, 12'h020, 3'd0, 1'b1, 4'd2, 3'd0);
        set_bank(3, 12'h030, 3'd0, 1'b0, 4'd0, 3'd0);
        set_bank(4, 12'h000, 3'd0, 1'b1, 4'd0, 3'd0);
        set_bank(5, 12'hFFC, 3'd0, 1'b1, 4'd0, 3'd0);
        set_bank(6, 12'h010, 3'd0, 1'b1, 4'd0, 3'd0);
        set_bank(7, 12'h080, 3'd0, 1'b0, 4'd0, 3'd0);

        repeat (3) @(negedge clk);
        chk("R3 reset: no chip select", 32'(cs_n), 32'hFF);
        chk("R3 reset: strobes idle", {30'd0, rd_n, wr_n}, 32'd3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset: ready", 32'(ready), 32'd1);
        chk("R10 reset: no done", 32'(done), 32'd0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            repeat (4) @(negedge clk);
            run_acc(VT[v].a, VT[v].sz, VT[v].w, VT[v].wd, lead, nstb, tot, csi, ef, rd, wimg, wm);
            if (VT[v].bank == 4'd15) begin
                chk("R1 R2 R9 undefined access flagged", 32'(ef), 32'd1);
                chk("R1 R2 R9 undefined access drives no strobe", 32'(nstb), 32'd0);
                chk("R10 err returned next cycle", 32'(tot), 32'd0);
            end else begin
                em = exp_mask(VT[v].a, VT[v].sz);
                chk("R1 R9 defined access no err", 32'(ef), 32'd0);
                chk("R2 R3 selected chip select", 32'(csi), 32'(VT[v].bank));
                chk("R4 R5 strobe cycles", 32'(nstb), 32'(VT[v].nstb));
                chk("R8 no float after quiet gap", 32'(lead), 32'd0);
                chk("R10 done right after last strobe", 32'(tot), 32'(lead + nstb));
                if (VT[v].w) begin
                    chk("R6 byte enable mask", 32'(wm), 32'(em));
                    chk("R6 written bytes", wimg & m32(em), VT[v].wd & m32(em));
                end else begin
                    chk("R7 read data lanes", rd, exp_rd(VT[v].a, VT[v].sz));
                end
            end
        end

        // float / turnaround scenarios
        repeat (5) @(negedge clk);
        run_acc(32'h0040_0000, 2'd1, 1'b1, 32'h0000_1234, lead, nstb, tot, csi, ef, rd, wimg, wm);
        run_acc(32'h0100_0000, 2'd0, 1'b0, 32'h0, lead, nstb, tot, csi, ef, rd, wimg, wm);
        chk("R8 bank change waits full float of previous bank", 32'(lead), 32'd2);
        chk("R8 read after float returns data", rd, exp_rd(32'h0100_0000, 2'd0));
        @(negedge clk);
        run_acc(32'h0040_0004, 2'd1, 1'b0, 32'h0, lead, nstb, tot, csi, ef, rd, wimg, wm);
        chk("R8 float shortened by one idle cycle", 32'(lead), 32'd2);
        run_acc(32'h0040_0006, 2'd1, 1'b0, 32'h0, lead, nstb, tot, csi, ef, rd, wimg, wm);
        chk("R8 same bank same direction no float", 32'(lead), 32'd0);
        run_acc(32'h0040_0008, 2'd0, 1'b1, 32'h0000_0077, lead, nstb, tot, csi, ef, rd, wimg, wm);
        chk("R8 direction reversal waits float", 32'(lead), 32'd2);
        chk("R6 byte write after float", 32'(wm), 32'b0001);
        run_acc(32'h0200_0000, 2'd0, 1'b1, 32'h0000_0055, lead, nstb, tot, csi, ef, rd, wimg, wm);
        chk("R8 change of bank after float-2 bank", 32'(lead), 32'd2);
        chk("R4 wait states 2 give 3 strobe cycles", 32'(nstb), 32'd3);
        run_acc(32'h0040_0000, 2'd0, 1'b0, 32'h0, lead, nstb, tot, csi, ef, rd, wimg, wm);
        chk("R8 zero-float bank imposes no wait", 32'(lead), 32'd0);
        repeat (4) @(negedge clk);
        run_acc(32'h0040_0003, 2'd0, 1'b0, 32'h0, lead, nstb, tot, csi, ef, rd, wimg, wm);
        chk("R7 odd byte read from 16-bit bank", rd, exp_rd(32'h0040_0003, 2'd0));

        if (!summary_done) begin
            summary_done = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
        end
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        if (!summary_done) begin
            summary_done = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
        end
        $finish;
    end
endmodule